// File: doc/BRIEF.md
# Sign-Magnitude Shift-Add Multiplier

This block multiplies two sign-magnitude numbers over several clock cycles. A one-cycle request loads the two magnitudes. The multiplicand goes into a holding register, the multiplier goes into a shift register, and the upper product half is cleared. For each of the N magnitude bits, the block tests the low bit of the multiplier register. When that bit is set, the multiplicand is added into the upper half. The combined upper half and multiplier register then shift right by one. The carry out of the addition enters at the top, so no product bit is lost.

The product sign does not pass through the adder. A separate register captures the XOR of the operand signs when the operands are loaded. At the end, that value is forced positive if the magnitude is zero. After the last iteration the block raises a one-cycle completion pulse. The 2N-bit magnitude and its sign then stay valid until the next accepted request. Requests that arrive while an operation is running are dropped.

Top module: `smag_mult`

## Requirements
- R1: A request (`go_i` high while `busy_o` is low) is accepted on that clock edge, and `busy_o` reads 1 in the following cycle.
- R2: Exactly N iterations run. `fin_o` goes high on the Nth clock edge after the accepting edge, and `busy_o` falls on that same edge.
- R3: When `fin_o` is high, `mag_o` equals the unsigned product `mcand_i * mplier_i` of the magnitudes captured at acceptance.
- R4: The full 2N-bit magnitude is correct at the operand maximums, so no carry is lost (for N=4, 15*15 gives 225).
- R5: When `fin_o` is high and the magnitude is nonzero, `sgn_o` equals `mcand_sgn_i ^ mplier_sgn_i` as captured at acceptance, where 1 means negative.
- R6: When `fin_o` is high and the magnitude is zero, `sgn_o` is 0, whatever the operand signs.
- R7: `fin_o` is high for exactly one cycle per accepted request.
- R8: A request raised while `busy_o` is high is ignored. It changes neither the result nor the completion cycle.
- R9: While idle with no request, `mag_o` and `sgn_o` hold their values.
- R10: After synchronous reset, `busy_o`, `fin_o`, `sgn_o` and `mag_o` are all 0.
- R11: A request raised in the cycle where `fin_o` is high is accepted and starts a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Request to start a multiplication |
| mcand_sgn_i | input | 1 | Multiplicand sign (1 = negative) |
| mcand_i | input | N | Multiplicand magnitude |
| mplier_sgn_i | input | 1 | Multiplier sign (1 = negative) |
| mplier_i | input | N | Multiplier magnitude |
| busy_o | output | 1 | Iterations in progress |
| fin_o | output | 1 | One-cycle completion pulse |
| mag_o | output | 2N | Product magnitude |
| sgn_o | output | 1 | Product sign |

## Verification
The completion pulse and a new request can fall in the same cycle. The bench provokes this by raising the next request in exactly the cycle where `fin_o` is high. It then judges that the finished result was presented correctly and that the new operation completes N cycles later with its own product and sign. A second collision is a request raised in the middle of a run. For that case the bench expects the original result at the original completion cycle. An exhaustive sweep over all 4-bit magnitudes and all sign pairs covers the carry and zero-sign corners.

// File: rtl/smag_mult_pkg.sv
package smag_mult_pkg;
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/smag_mult_ctrl.sv
module smag_mult_ctrl
  import smag_mult_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic load_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic fin_o
);
  localparam int CW = cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          busy_q, fin_q;
  logic [CW-1:0] cnt_q;

  assign load_o = go_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (cnt_q == LAST);
  assign busy_o = busy_q;
  assign fin_o  = fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      fin_q <= last_o;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) busy_q <= 1'b0;
      end
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> !fin_q);
  p_busy_end_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> fin_q);
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q <= LAST));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && go_i && !last_o) |=> busy_q);
endmodule

// File: rtl/smag_mult_dp.sv
module smag_mult_dp #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic [2*N-1:0] prod_o,
  output logic [2*N-1:0] prod_nxt_o
);
  logic [N-1:0] hi_q, lo_q, y_q;
  logic [N:0]   sum;

  always_comb begin
    sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, y_q} : '0);
    prod_nxt_o = {sum, lo_q[N-1:1]};
  end

  assign prod_o = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
      y_q  <= '0;
    end else if (load_i) begin
      hi_q <= '0;
      lo_q <= mplier_i;
      y_q  <= mcand_i;
    end else if (step_i) begin
      hi_q <= sum[N:1];
      lo_q <= {sum[0], lo_q[N-1:1]};
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> $stable(prod_o));
  p_y_stable_r8: assert property (@(posedge clk) disable iff (rst)
    step_i |=> $stable(y_q));
endmodule

// File: rtl/smag_mult_sign.sv
module smag_mult_sign #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_i,
  input  logic           last_i,
  input  logic           a_sgn_i,
  input  logic           b_sgn_i,
  input  logic [2*N-1:0] prod_nxt_i,
  output logic           sgn_o
);
  logic xor_q, sgn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xor_q <= 1'b0;
      sgn_q <= 1'b0;
    end else begin
      if (load_i) xor_q <= a_sgn_i ^ b_sgn_i;
      if (last_i) sgn_q <= xor_q & (|prod_nxt_i);
    end
  end

  assign sgn_o = sgn_q;

  p_sgn_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !last_i |=> $stable(sgn_q));
endmodule

// File: rtl/smag_mult.sv
module smag_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go_i,
  input  logic           mcand_sgn_i,
  input  logic [N-1:0]   mcand_i,
  input  logic           mplier_sgn_i,
  input  logic [N-1:0]   mplier_i,
  output logic           busy_o,
  output logic           fin_o,
  output logic [2*N-1:0] mag_o,
  output logic           sgn_o
);
  logic load, step, last;
  logic [2*N-1:0] prod_nxt;

  smag_mult_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst(rst), .go_i(go_i),
    .load_o(load), .step_o(step), .last_o(last),
    .busy_o(busy_o), .fin_o(fin_o)
  );

  smag_mult_dp #(.N(N)) u_dp (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .prod_o(mag_o), .prod_nxt_o(prod_nxt)
  );

  smag_mult_sign #(.N(N)) u_sign (
    .clk(clk), .rst(rst), .load_i(load), .last_i(last),
    .a_sgn_i(mcand_sgn_i), .b_sgn_i(mplier_sgn_i),
    .prod_nxt_i(prod_nxt), .sgn_o(sgn_o)
  );

  p_zero_pos_r6: assert property (@(posedge clk) disable iff (rst)
    (fin_o && (mag_o == '0)) |-> !sgn_o);
  p_fin_idle_r2: assert property (@(posedge clk) disable iff (rst)
    fin_o |-> !busy_o);
endmodule

// File: tb/smag_mult_bench.sv
module smag_mult_bench;
  localparam int N = 4;
  localparam int M = 1 << N;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic as_i = 1'b0, bs_i = 1'b0;
  logic [N-1:0] a_i = '0, b_i = '0;
  logic busy, fin, sgn;
  logic [2*N-1:0] mag;
  int checks = 0, fails = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  smag_mult #(.N(N)) u_smag_mult (
    .clk(clk), .rst(rst), .go_i(go),
    .mcand_sgn_i(as_i), .mcand_i(a_i),
    .mplier_sgn_i(bs_i), .mplier_i(b_i),
    .busy_o(busy), .fin_o(fin), .mag_o(mag), .sgn_o(sgn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge with the request already being set up.
  task automatic launch(input int a, input bit as, input int b, input bit bs);
    go = 1'b1; a_i = N'(a); b_i = N'(b); as_i = as; bs_i = bs;
    @(posedge clk); @(negedge clk);
    go = 1'b0;
    chk("R1 busy after accept", int'(busy), 1);
  endtask

  task automatic run_out(input int a, input bit as, input int b, input bit bs,
                         input bit inject);
    int p = a * b;
    for (int i = 1; i <= N; i++) begin
      if (inject && i == 2) begin
        go = 1'b1; a_i = ~N'(a); b_i = ~N'(b); as_i = ~as; bs_i = as;
      end
      @(posedge clk); @(negedge clk);
      go = 1'b0;
      if (i < N) begin
        if (fin) chk("R2 early fin", int'(fin), 0);
      end else begin
        chk("R2 fin at Nth edge", int'(fin), 1);
        chk("R2 busy fell", int'(busy), 0);
        if (a == M-1 && b == M-1) chk("R4 max product", int'(mag), p);
        else if (inject) chk("R8 result unaffected", int'(mag), p);
        else chk("R3 product", int'(mag), p);
        if (p == 0) chk("R6 zero positive", int'(sgn), 0);
        else chk("R5 sign", int'(sgn), int'(as ^ bs));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 fin", int'(fin), 0);
    chk("R10 mag", int'(mag), 0);
    chk("R10 sgn", int'(sgn), 0);
    rst = 1'b0;
    @(negedge clk);
    // exhaustive sweep
    for (int a = 0; a < M; a++)
      for (int b = 0; b < M; b++)
        for (int s = 0; s < 4; s++) begin
          logic [2*N-1:0] keep_mag;
          logic keep_sgn;
          launch(a, s[0], b, s[1]);
          run_out(a, s[0], b, s[1], 1'b0);
          keep_mag = mag; keep_sgn = sgn;
          @(negedge clk);
          if (fin) chk("R7 single pulse", int'(fin), 0);
          @(negedge clk);
          if (mag != keep_mag) chk("R9 mag hold", int'(mag), int'(keep_mag));
          if (sgn != keep_sgn) chk("R9 sgn hold", int'(sgn), int'(keep_sgn));
        end
    // request while busy must be ignored
    launch(13, 1'b1, 11, 1'b0);
    run_out(13, 1'b1, 11, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 no extra run", int'(busy), 0);
    chk("R7 fin dropped", int'(fin), 0);
    // back-to-back: new request in the completion cycle
    launch(9, 1'b0, 7, 1'b1);
    run_out(9, 1'b0, 7, 1'b1, 1'b0);
    launch(15, 1'b1, 15, 1'b1);
    chk("R11 accepted in fin cycle", int'(busy), 1);
    run_out(15, 1'b1, 15, 1'b1, 1'b0);
    launch(0, 1'b1, 5, 1'b0);
    run_out(0, 1'b1, 5, 1'b0, 1'b0);
    done_run = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done_run) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule